// File: doc/BRIEF.md
# Charge-Pump Fastlock Timer Controller

This block sits beside the feedback-counter and function registers of a PLL synthesizer. Its job is to pick which of two programmed charge-pump current codes drives the pump. While the loop is settling on a new frequency it selects a larger secondary current, and once the loop is stable it selects the primary current. Software asks for fastlock by writing a CP-gain bit of 1 together with a feedback-counter load. Fastlock then ends in one of two ways, chosen by a mode bit in the function word.

In manual mode, fastlock lasts until software writes the gain bit back to 0. In timed mode, a down-counter clocked by a timeout tick counts out a programmable interval. When the interval ends, the counter clears the stored gain bit itself, and the output returns to the primary code. A reset from the power-down logic reloads the timer and drops the block back to the primary current. Serial shifting of the registers and the analogue current generation are handled elsewhere.

Top module: `fastlock_ctl`

## Requirements
- R1: After reset, cp_code is 0, gain_bit is 0 and fastlock_on is 0.
- R2: When the enable bit (function word bit 9) is 0, cp_code equals the primary code even if the stored gain bit is 1.
- R3: With enable at 1, a feedback load carrying fb_gain=1 sets gain_bit and switches cp_code to the secondary code from the next cycle.
- R4: In manual mode (bit 10 = 0), ticks never clear gain_bit; only a feedback load with fb_gain=0 ends fastlock.
- R5: In timed mode (bit 10 = 1), gain_bit clears on exactly the ((code+1)*4)-th tick after the gain=1 load, where code is bits 14..11. cp_code then returns to the primary code.
- R6: The timer counts only while enable is 1, timed mode is selected and gain_bit is 1. Ticks at any other time leave the remaining interval unchanged.
- R7: A feedback load with fb_gain=1 during a running timed interval restarts the interval at its full length.
- R8: A pd_rst pulse clears gain_bit, puts cp_code back to the primary code and reloads the timer to its full length.
- R9: The primary current code is taken from function word bits 17..15, and the secondary code from bits 20..18.
- R10: A function-word write does not change the stored gain bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_rst | input | 1 | Synchronous reset pulse from the power-down logic |
| func_wr | input | 1 | Function word write strobe |
| func_word | input | 24 | Function word contents |
| fb_wr | input | 1 | Feedback-counter load strobe |
| fb_gain | input | 1 | CP-gain bit written with the feedback load |
| tick | input | 1 | Timeout-clock tick, one cycle wide |
| cp_code | output | 3 | Active charge-pump current code |
| gain_bit | output | 1 | Stored CP-gain bit |
| fastlock_on | output | 1 | High while the secondary current is selected |

## Verification
The bench uses the default build: a 4-bit timeout code, a tick multiplier of 4 and 3-bit current codes. With these values every one of the sixteen timeouts, up to 64 ticks long, can be swept in full, with a check one tick before and one tick at each expiry. All eight primary codes, each paired with a secondary code, are tried with enable low and high. Separate scenarios cover a restart in the middle of an interval, a power-down reset in the middle of an interval, and ticks that arrive while the timer is gated off; each scenario is followed by a full-length interval that shows the timer was reloaded.

// File: rtl/fl_pkg.sv
package fl_pkg;
  localparam int TC_W      = 4;
  localparam int TICK_MULT = 4;
  localparam int CUR_W     = 3;
  localparam int MAX_TICKS = (1 << TC_W) * TICK_MULT;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  // timeout length in ticks for a given code: (code + 1) * multiplier
  function automatic logic [CNT_W-1:0] ticks_for_code(input logic [TC_W-1:0] code);
    int n;
    n = (int'(code) + 1) * TICK_MULT;
    return CNT_W'(n);
  endfunction
endpackage

// File: rtl/fl_func_reg.sv
module fl_func_reg
  import fl_pkg::*;
#(
  parameter int FW       = 24,
  parameter int EN_POS   = 9,
  parameter int MODE_POS = 10,
  parameter int TC_LSB   = 11,
  parameter int PRI_LSB  = 15,
  parameter int SEC_LSB  = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [FW-1:0]    word,
  output logic             en_q,
  output logic             mode_q,
  output logic [TC_W-1:0]  tcode_q,
  output logic [CUR_W-1:0] pri_q,
  output logic [CUR_W-1:0] sec_q
);
  logic unused_word_bits;
  assign unused_word_bits = ^word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mode_q  <= 1'b0;
      tcode_q <= '0;
      pri_q   <= '0;
      sec_q   <= '0;
    end else if (wr) begin
      en_q    <= word[EN_POS];
      mode_q  <= word[MODE_POS];
      tcode_q <= word[TC_LSB +: TC_W];
      pri_q   <= word[PRI_LSB +: CUR_W];
      sec_q   <= word[SEC_LSB +: CUR_W];
    end
  end
endmodule

// File: rtl/fl_timer.sv
module fl_timer
  import fl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_rst,
  input  logic             load,
  input  logic             run,
  input  logic             tick,
  input  logic [TC_W-1:0]  tcode,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  logic [CNT_W-1:0] full_cnt;
  assign full_cnt = ticks_for_code(tcode);

  // last tick of a running interval; a reload in the same cycle wins
  assign expire = run && tick && (cnt_q == CNT_W'(1)) && !load && !pd_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= ticks_for_code('0);
    else if (pd_rst || load || expire)
      cnt_q <= full_cnt;
    else if (run && tick)
      cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/fl_cur_mux.sv
module fl_cur_mux
  import fl_pkg::*;
(
  input  logic             sel_sec,
  input  logic [CUR_W-1:0] pri,
  input  logic [CUR_W-1:0] sec,
  output logic [CUR_W-1:0] code
);
  for (genvar b = 0; b < CUR_W; b++) begin : g_bit
    assign code[b] = sel_sec ? sec[b] : pri[b];
  end
endmodule

// File: rtl/fastlock_ctl.sv
module fastlock_ctl
  import fl_pkg::*;
#(
  parameter int FW       = 24,
  parameter int EN_POS   = 9,
  parameter int MODE_POS = 10,
  parameter int TC_LSB   = 11,
  parameter int PRI_LSB  = 15,
  parameter int SEC_LSB  = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_rst,
  input  logic             func_wr,
  input  logic [FW-1:0]    func_word,
  input  logic             fb_wr,
  input  logic             fb_gain,
  input  logic             tick,
  output logic [CUR_W-1:0] cp_code,
  output logic             gain_bit,
  output logic             fastlock_on
);
  logic             en_q, mode_q;
  logic [TC_W-1:0]  tcode_q;
  logic [CUR_W-1:0] pri_q, sec_q;
  logic [CNT_W-1:0] cnt_q;
  logic             gain_q;
  logic             run_w;
  logic             expire_w;
  logic             set_w;

  fl_func_reg #(
    .FW(FW), .EN_POS(EN_POS), .MODE_POS(MODE_POS),
    .TC_LSB(TC_LSB), .PRI_LSB(PRI_LSB), .SEC_LSB(SEC_LSB)
  ) u_freg (
    .clk(clk), .rst_n(rst_n), .wr(func_wr), .word(func_word),
    .en_q(en_q), .mode_q(mode_q), .tcode_q(tcode_q),
    .pri_q(pri_q), .sec_q(sec_q)
  );

  assign run_w = en_q && mode_q && gain_q;
  assign set_w = fb_wr && fb_gain;

  fl_timer u_tmr (
    .clk(clk), .rst_n(rst_n), .pd_rst(pd_rst), .load(fb_wr),
    .run(run_w), .tick(tick), .tcode(tcode_q),
    .cnt_q(cnt_q), .expire(expire_w)
  );

  // stored gain bit: power-down beats a write, a write beats expiry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gain_q <= 1'b0;
    else if (pd_rst)   gain_q <= 1'b0;
    else if (fb_wr)    gain_q <= fb_gain;
    else if (expire_w) gain_q <= 1'b0;
  end

  assign fastlock_on = en_q && gain_q;
  assign gain_bit    = gain_q;

  fl_cur_mux u_mux (
    .sel_sec(fastlock_on), .pri(pri_q), .sec(sec_q), .code(cp_code)
  );

  logic unused_set;
  assign unused_set = set_w;
endmodule

// File: rtl/fl_ctl_chk.sv
module fl_ctl_chk
  import fl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             pd_rst,
  input logic             fb_wr,
  input logic             fb_gain,
  input logic             tick,
  input logic [CUR_W-1:0] cp_code,
  input logic             gain_bit,
  input logic             en_q,
  input logic             mode_q,
  input logic [CUR_W-1:0] pri_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             run_w,
  input logic             expire_w
);
  // R8
  pd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_rst |=> !gain_bit && (cp_code == pri_q));

  // R3
  gain_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_wr && fb_gain && !pd_rst |=> gain_bit);

  // R4
  manual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q && gain_bit && !fb_wr && !pd_rst |=> gain_bit);

  // R5
  expire_revert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w |=> !gain_bit && (cp_code == pri_q));

  // R6
  idle_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_w && !fb_wr && !pd_rst |=> $stable(cnt_q));

  // R2
  disabled_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> cp_code == pri_q);

  // R5
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0);

  logic unused_chk;
  assign unused_chk = tick;
endmodule

bind fastlock_ctl fl_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pd_rst(pd_rst), .fb_wr(fb_wr), .fb_gain(fb_gain),
  .tick(tick), .cp_code(cp_code), .gain_bit(gain_bit), .en_q(en_q),
  .mode_q(mode_q), .pri_q(pri_q), .cnt_q(cnt_q), .run_w(run_w),
  .expire_w(expire_w)
);

// File: tb/test_fastlock_ctl.sv
module test_fastlock_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pd_rst = 1'b0;
  logic          func_wr = 1'b0;
  logic [FW-1:0] func_word = '0;
  logic          fb_wr = 1'b0;
  logic          fb_gain = 1'b0;
  logic          tick = 1'b0;
  logic [2:0]    cp_code;
  logic          gain_bit;
  logic          fastlock_on;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fastlock_ctl i_fastlock_ctl (
    .clk(clk), .rst_n(rst_n), .pd_rst(pd_rst), .func_wr(func_wr),
    .func_word(func_word), .fb_wr(fb_wr), .fb_gain(fb_gain), .tick(tick),
    .cp_code(cp_code), .gain_bit(gain_bit), .fastlock_on(fastlock_on)
  );

  function automatic logic [FW-1:0] mkword(input bit en, input bit mode,
      input int tc, input int pri, input int sec);
    logic [FW-1:0] w;
    w = '0;
    w[9]     = en;
    w[10]    = mode;
    w[14:11] = tc[3:0];
    w[17:15] = pri[2:0];
    w[20:18] = sec[2:0];
    return w;
  endfunction

  function automatic int span(input int tc);
    return 4 * tc + 4;
  endfunction

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_func(input logic [FW-1:0] w);
    func_wr = 1'b1; func_word = w; cyc(); func_wr = 1'b0;
  endtask

  task automatic wr_fb(input bit g);
    fb_wr = 1'b1; fb_gain = g; cyc(); fb_wr = 1'b0; fb_gain = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; cyc(); tick = 1'b0; cyc();
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    // R1 reset state
    chk("R1 cp_code", cp_code, 0);
    chk("R1 gain_bit", gain_bit, 0);
    chk("R1 fastlock_on", fastlock_on, 0);
    rst_n = 1'b1;
    cyc();
    chk("R1 cp_code after release", cp_code, 0);

    // R2 / R9 / R3: all primary codes, enable low then high
    for (int p = 0; p < 8; p++) begin
      wr_func(mkword(0, 0, 0, p, 7 - p));
      wr_fb(1);
      chk("R2 disabled primary", cp_code, p);
      chk("R2 gain stored", gain_bit, 1);
      wr_func(mkword(1, 0, 0, p, 7 - p));
      chk("R10 gain kept over func write", gain_bit, 1);
      chk("R9 secondary field", cp_code, 7 - p);
      wr_fb(0);
      chk("R9 primary field", cp_code, p);
      wr_fb(1);
      chk("R3 enter fastlock", cp_code, 7 - p);
      chk("R3 fastlock_on", fastlock_on, 1);
      wr_fb(0);
    end

    // R4 manual mode ignores ticks
    wr_func(mkword(1, 0, 0, 2, 5));
    wr_fb(1);
    ticks(70);
    chk("R4 ticks ignored gain", gain_bit, 1);
    chk("R4 ticks ignored code", cp_code, 5);
    wr_fb(0);
    chk("R4 software exit", cp_code, 2);

    // R5 every timeout code
    for (int tc = 0; tc < 16; tc++) begin
      wr_func(mkword(1, 1, tc, 1, 6));
      wr_fb(1);
      ticks(span(tc) - 1);
      chk("R5 before expiry", cp_code, 6);
      ticks(1);
      chk("R5 gain cleared", gain_bit, 0);
      chk("R5 primary after expiry", cp_code, 1);
    end

    // R6 ticks while disabled do not consume the interval
    wr_func(mkword(0, 1, 3, 3, 4));
    wr_fb(1);
    ticks(40);
    chk("R6 gain kept while gated", gain_bit, 1);
    wr_func(mkword(1, 1, 3, 3, 4));
    chk("R10 gain kept on enable", gain_bit, 1);
    ticks(span(3) - 1);
    chk("R6 full interval remains", cp_code, 4);
    ticks(1);
    chk("R6 expiry after full interval", cp_code, 3);

    // R6 manual-mode ticks do not consume the interval
    wr_func(mkword(1, 0, 1, 3, 4));
    wr_fb(1);
    ticks(20);
    wr_func(mkword(1, 1, 1, 3, 4));
    ticks(span(1) - 1);
    chk("R6 mode switch full interval", gain_bit, 1);
    ticks(1);
    chk("R6 mode switch expiry", gain_bit, 0);

    // R7 restart mid-interval
    wr_func(mkword(1, 1, 2, 0, 7));
    wr_fb(1);
    ticks(8);
    wr_fb(1);
    ticks(span(2) - 1);
    chk("R7 restarted interval", cp_code, 7);
    ticks(1);
    chk("R7 expiry after restart", cp_code, 0);

    // R8 power-down reset
    wr_fb(1);
    ticks(5);
    wr_func(mkword(1, 1, 2, 0, 7));
    chk("R10 mid-interval func write", gain_bit, 1);
    pd_rst = 1'b1; cyc(); pd_rst = 1'b0;
    chk("R8 gain cleared", gain_bit, 0);
    chk("R8 primary code", cp_code, 0);
    wr_fb(1);
    ticks(span(2) - 1);
    chk("R8 timer reloaded", gain_bit, 1);
    ticks(1);
    chk("R8 expiry after reload", gain_bit, 0);

    finish_run();
  end
endmodule